// File: doc/BRIEF.md
# Firmware Download Register Target

This block sits on the device side of a management register bus and takes in a program image one 16-bit register write at a time. A host first points a 32-bit byte load pointer at the destination, then streams words into a data port. The block places each word into local program RAM through a simple write port and moves the pointer forward. As the words pass through, it keeps a running byte checksum. The host reads that checksum back to confirm the transfer, and the read clears it so the next section starts from zero.

A boot control/status register tells the host that the device is waiting for code. Once the image is in place, the host sets a load flag in that register. After a fixed, configurable delay, which stands in for the processor boot time, the block reports that the application is running. A fault input latches a sticky fatal flag into the same register. Register accesses arrive already decoded, as a bus controller would present them after parsing the serial management frames.

Top module: `fwdl_regs`

## Requirements
- R1: After reset the load pointer is 0, the checksum is 0, and the boot register (0xC050) reads 0x0002, meaning no fatal flag, progress 01 (waiting) and no load or start flag.
- R2: A write to 0xD0F0 loads pointer bits 15:0 and a write to 0xD0F1 loads pointer bits 31:16. Reading either address returns that half of the pointer. Neither write changes the checksum.
- R3: A write to the data port 0xD0F2 raises ram_we in the same cycle, with ram_addr equal to pointer bits RAM_AW:1 and ram_wdata equal to the written word. Afterwards the 32-bit pointer has advanced by 2, carrying into the upper half when needed.
- R4: The checksum register 0xD0F3 holds the sum, modulo 65536, of the low byte plus the high byte of every word written to the data port since it was last cleared.
- R5: A read of 0xD0F3 returns the current checksum in that cycle, and the checksum is 0 from the next cycle onward.
- R6: The boot register uses these bits: bit 0 fatal, bits 2:1 progress (01 waiting, 10 booting, 11 running), bit 4 application started, bit 6 application loaded. All other bits read 0.
- R7: Writing bit 6 as 1 to 0xC050 sets the loaded flag, which stays set. The started flag sets exactly BOOT_CYCLES clock edges after the edge that took the write. A write with bit 6 clear has no effect.
- R8: A high boot_fault_i at a clock edge sets the fatal flag, which holds until reset.
- R9: Reads of any other address return 0, and writes to any other address change neither the pointer, the checksum nor the boot register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of reg_rd |
| boot_fault_i | input | 1 | Boot fault indication |
| ram_we | output | 1 | Program RAM write enable |
| ram_addr | output | RAM_AW | Program RAM word address |
| ram_wdata | output | 16 | Program RAM write data |
| app_loaded_o | output | 1 | Application load requested |
| app_started_o | output | 1 | Application running |

## Verification
The data port is driven with three kinds of stream. An arithmetic word sequence longer than the RAM depth shows whether the byte lanes are summed separately and whether the RAM address wraps on the low pointer bits. A long run of all-ones words forces the checksum through a 16-bit wrap, which an accumulator of the wrong width would get wrong. A single write at pointer 0x0000FFFE exposes a missing carry into the upper pointer half. The boot sequence is polled on every cycle after the load write, so a start that comes early or late by a single edge is seen. Unmapped accesses are followed by readback of the pointer, checksum and boot register.

// File: rtl/fwdl_pkg.sv
package fwdl_pkg;
  localparam logic [15:0] REG_PTR_LO = 16'hD0F0;
  localparam logic [15:0] REG_PTR_HI = 16'hD0F1;
  localparam logic [15:0] REG_DATA   = 16'hD0F2;
  localparam logic [15:0] REG_CSUM   = 16'hD0F3;
  localparam logic [15:0] REG_BOOT   = 16'hC050;

  localparam int BIT_FATAL   = 0;
  localparam int BIT_STARTED = 4;
  localparam int BIT_LOADED  = 6;

  typedef enum logic [1:0] {
    PROG_WAIT    = 2'b01,
    PROG_BOOTING = 2'b10,
    PROG_RUNNING = 2'b11
  } prog_e;

  function automatic logic [15:0] word_bytesum(input logic [15:0] w);
    return {8'h00, w[7:0]} + {8'h00, w[15:8]};
  endfunction

  function automatic logic [15:0] boot_word(input logic fatal,
                                            input logic loaded,
                                            input logic started);
    prog_e p;
    logic [15:0] r;
    p = started ? PROG_RUNNING : (loaded ? PROG_BOOTING : PROG_WAIT);
    r = 16'h0000;
    r[BIT_FATAL]   = fatal;
    r[2:1]         = p;
    r[BIT_STARTED] = started;
    r[BIT_LOADED]  = loaded;
    return r;
  endfunction
endpackage

// File: rtl/fwdl_ptr.sv
module fwdl_ptr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic        adv,
  input  logic [15:0] wdata,
  output logic [31:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ptr <= 32'h0;
    else if (wr_lo) ptr[15:0]  <= wdata;
    else if (wr_hi) ptr[31:16] <= wdata;
    else if (adv)   ptr <= ptr + 32'd2;
  end
endmodule

// File: rtl/fwdl_csum.sv
module fwdl_csum
  import fwdl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        add,
  input  logic        clr,
  input  logic [15:0] word,
  output logic [15:0] csum
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) csum <= 16'h0;
    else if (add)      csum <= csum + word_bytesum(word);
  end
endmodule

// File: rtl/fwdl_boot.sv
module fwdl_boot #(
  parameter int BOOT_CYCLES = 200,
  localparam int CW = $clog2(BOOT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_req,
  input  logic fault,
  output logic fatal,
  output logic loaded,
  output logic started
);
  localparam logic [CW-1:0] LAST = CW'(BOOT_CYCLES - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fatal <= 1'b0; loaded <= 1'b0; started <= 1'b0; cnt <= '0;
    end else begin
      if (fault) fatal <= 1'b1;
      if (load_req) loaded <= 1'b1;
      if (loaded && !started) begin
        if (cnt == LAST) started <= 1'b1;
        else             cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fwdl_regs.sv
module fwdl_regs
  import fwdl_pkg::*;
#(
  parameter int RAM_AW      = 10,
  parameter int BOOT_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [15:0]       reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              boot_fault_i,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [15:0]       ram_wdata,
  output logic              app_loaded_o,
  output logic              app_started_o
);
  logic wr_lo_ev, wr_hi_ev, wr_data_ev, wr_boot_ev, rd_csum_ev, load_req_ev;
  logic [31:0] ptr_q;
  logic [15:0] csum_q;
  logic fatal_q, loaded_q, started_q;

  assign wr_lo_ev    = reg_wr && (reg_addr == REG_PTR_LO);
  assign wr_hi_ev    = reg_wr && (reg_addr == REG_PTR_HI);
  assign wr_data_ev  = reg_wr && (reg_addr == REG_DATA);
  assign wr_boot_ev  = reg_wr && (reg_addr == REG_BOOT);
  assign rd_csum_ev  = reg_rd && (reg_addr == REG_CSUM);
  assign load_req_ev = wr_boot_ev && reg_wdata[BIT_LOADED];

  fwdl_ptr ptr_i (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo_ev), .wr_hi(wr_hi_ev),
    .adv(wr_data_ev), .wdata(reg_wdata), .ptr(ptr_q)
  );

  fwdl_csum csum_i (
    .clk(clk), .rst_n(rst_n), .add(wr_data_ev), .clr(rd_csum_ev),
    .word(reg_wdata), .csum(csum_q)
  );

  fwdl_boot #(.BOOT_CYCLES(BOOT_CYCLES)) boot_i (
    .clk(clk), .rst_n(rst_n), .load_req(load_req_ev), .fault(boot_fault_i),
    .fatal(fatal_q), .loaded(loaded_q), .started(started_q)
  );

  assign ram_we        = wr_data_ev;
  assign ram_addr      = ptr_q[RAM_AW:1];
  assign ram_wdata     = reg_wdata;
  assign app_loaded_o  = loaded_q;
  assign app_started_o = started_q;

  always_comb begin
    reg_rdata = 16'h0;
    if (reg_rd) begin
      unique case (reg_addr)
        REG_PTR_LO: reg_rdata = ptr_q[15:0];
        REG_PTR_HI: reg_rdata = ptr_q[31:16];
        REG_CSUM:   reg_rdata = csum_q;
        REG_BOOT:   reg_rdata = boot_word(fatal_q, loaded_q, started_q);
        default:    reg_rdata = 16'h0;
      endcase
    end
  end
endmodule

// File: rtl/fwdl_chk.sv
module fwdl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_rd,
  input logic [15:0] reg_addr,
  input logic [15:0] reg_rdata,
  input logic [31:0] ptr_q,
  input logic [15:0] csum_q,
  input logic        loaded_q,
  input logic        started_q,
  input logic        fatal_q,
  input logic        wr_lo_ev,
  input logic        wr_hi_ev,
  input logic        wr_data_ev,
  input logic        wr_boot_ev,
  input logic        rd_csum_ev
);
  logic mapped;
  assign mapped = (reg_addr == 16'hD0F0) || (reg_addr == 16'hD0F1) ||
                  (reg_addr == 16'hD0F3) || (reg_addr == 16'hC050);

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_ev |=> ptr_q == $past(ptr_q) + 32'd2);
  assert_csum_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_csum_ev |=> csum_q == 16'h0);
  assert_addr_keeps_csum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_ev || wr_hi_ev) |=> $stable(csum_q));
  assert_started_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |=> started_q);
  assert_started_needs_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> loaded_q);
  assert_fatal_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_q |=> fatal_q);
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !mapped) |-> reg_rdata == 16'h0);
  assert_one_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_lo_ev, wr_hi_ev, wr_data_ev, wr_boot_ev}));
endmodule

bind fwdl_regs fwdl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .ptr_q(ptr_q), .csum_q(csum_q),
  .loaded_q(loaded_q), .started_q(started_q), .fatal_q(fatal_q),
  .wr_lo_ev(wr_lo_ev), .wr_hi_ev(wr_hi_ev), .wr_data_ev(wr_data_ev),
  .wr_boot_ev(wr_boot_ev), .rd_csum_ev(rd_csum_ev)
);

// File: tb/fwdl_regs_tb.sv
module fwdl_regs_tb_top;
  localparam int AW = 6;
  localparam int BC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, fault = 0;
  logic [15:0] reg_addr = 0, reg_wdata = 0, reg_rdata, ram_wdata;
  logic ram_we, app_loaded, app_started;
  logic [AW-1:0] ram_addr;
  int errors = 0, checks = 0;
  logic done = 0;

  always #5 clk = ~clk;

  fwdl_regs #(.RAM_AW(AW), .BOOT_CYCLES(BC)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .boot_fault_i(fault), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .app_loaded_o(app_loaded), .app_started_o(app_started)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic w, input logic r, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
    #1;
  endtask

  task automatic rd_exp(input string req, input logic [15:0] a, input logic [15:0] exp);
    put(0, 1, a, 0);
    chk(req, {16'h0, reg_rdata}, {16'h0, exp});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] ptr;
    logic [15:0] sum;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_exp("R1 ptr_lo", 16'hD0F0, 16'h0);
    rd_exp("R1 ptr_hi", 16'hD0F1, 16'h0);
    rd_exp("R1 csum", 16'hD0F3, 16'h0);
    rd_exp("R1 boot", 16'hC050, 16'h0002);

    // R3/R4 arithmetic stream longer than RAM depth
    ptr = 32'h0; sum = 16'h0;
    for (int i = 0; i < 80; i++) begin
      w = 16'(i * 16'h1357) ^ 16'hA5C3;
      put(1, 0, 16'hD0F2, w);
      chk("R3 ram_we", {31'h0, ram_we}, 32'h1);
      chk("R3 ram_addr", {26'h0, ram_addr}, {26'h0, 6'((ptr >> 1) % 64)});
      chk("R3 ram_wdata", {16'h0, ram_wdata}, {16'h0, w});
      ptr = ptr + 2;
      sum = 16'((32'(sum) + (w & 16'hFF) + (w >> 8)) % 65536);
    end
    rd_exp("R3 ptr_lo", 16'hD0F0, ptr[15:0]);
    rd_exp("R5 csum value", 16'hD0F3, sum);
    rd_exp("R5 csum cleared", 16'hD0F3, 16'h0);

    // R4 wrap with all-ones
    sum = 0;
    for (int i = 0; i < 200; i++) put(1, 0, 16'hD0F2, 16'hFFFF);
    rd_exp("R4 csum wrap", 16'hD0F3, 16'((200 * 510) % 65536));

    // R2 pointer halves and csum untouched
    put(1, 0, 16'hD0F2, 16'h0102);
    put(1, 0, 16'hD0F0, 16'hFFFE);
    put(1, 0, 16'hD0F1, 16'h0000);
    rd_exp("R2 lo", 16'hD0F0, 16'hFFFE);
    rd_exp("R2 hi", 16'hD0F1, 16'h0000);
    put(0, 0, 0, 0);
    chk("R2 idle ram_we", {31'h0, ram_we}, 32'h0);
    put(1, 0, 16'hD0F2, 16'h0000);
    chk("R3 ram_addr at FFFE", {26'h0, ram_addr}, 32'h3F);
    rd_exp("R3 carry lo", 16'hD0F0, 16'h0000);
    rd_exp("R3 carry hi", 16'hD0F1, 16'h0001);
    rd_exp("R2 csum kept", 16'hD0F3, 16'h0003);

    // R9 unmapped
    put(1, 0, 16'hD0F2, 16'h0404);
    put(1, 0, 16'h1234, 16'hFFFF);
    put(1, 0, 16'hD0F4, 16'hFFFF);
    put(1, 0, 16'hC051, 16'hFFFF);
    rd_exp("R9 rd unmapped", 16'hD0F4, 16'h0);
    rd_exp("R9 rd data port", 16'hD0F2, 16'h0);
    rd_exp("R9 ptr kept", 16'hD0F0, 16'h0002);
    rd_exp("R9 boot kept", 16'hC050, 16'h0002);
    rd_exp("R9 csum kept", 16'hD0F3, 16'h0008);

    // R7 write without bit 6
    put(1, 0, 16'hC050, 16'hFFBF);
    rd_exp("R7 no load", 16'hC050, 16'h0002);
    chk("R7 loaded port", {31'h0, app_loaded}, 32'h0);

    // R7/R6 boot timing
    put(1, 0, 16'hC050, 16'h0040);
    for (int k = 1; k <= BC; k++) rd_exp("R7 booting", 16'hC050, 16'h0044);
    rd_exp("R7 running", 16'hC050, 16'h0056);
    chk("R7 started port", {31'h0, app_started}, 32'h1);
    put(1, 0, 16'hC050, 16'h0000);
    rd_exp("R7 loaded sticky", 16'hC050, 16'h0056);

    // R8 fault
    @(negedge clk); fault = 1;
    @(negedge clk); fault = 0;
    rd_exp("R8 fatal", 16'hC050, 16'h0057);
    rd_exp("R8 fatal held", 16'hC050, 16'h0057);
    rd_exp("R6 layout", 16'hC050, 16'h0057);
    put(0, 0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule